// File: doc/BRIEF.md
# Two-Channel Debug Break Comparator

This block watches the processor's bus cycles and raises a break request when a programmed condition is met. Channel A matches a single address. Channel B matches an address and can also match the data value. The data check goes through a per-bit mask, so chosen data bits can be left out of the comparison.

Software programs the unit through a small register port. Register select 0 holds the channel A address, 1 holds the channel B address, 2 holds the channel B data compare value and 3 holds the channel B data mask. Select 4 is the 16-bit control register, zero-extended on read. Selects 5 to 7 read as zero and ignore writes.

In the control register, bit 15 is match flag A and bit 14 is match flag B. Bit 10 is the channel A timing select and bit 6 is the channel B timing select. Bit 7 enables the channel B data check. Bit 3 selects sequential mode and bit 0 is the debug enable. All other bits read as 0.

The two channels can run independently. In sequential mode, a channel A hit arms the unit and a later channel B hit raises the request. Each channel also picks when its break takes effect: at once, before the instruction executes, or held until the instruction's completion strobe.

Top module: `dbg_break_unit`

## Requirements
- R1: After reset, the control register (select 4) reads 0 and `brk_req` is low.
- R2: Writing 0xFFFF to control reads back 0x04C9. Only bits 10, 7, 6, 3 and 0 are writable, and a 1 written to a flag bit (15 or 14) does not set that flag.
- R3: With enable=1, sequential=0 and A timing=0, `brk_req` is high in the same cycle as a valid bus cycle whose address equals the channel A address. A cycle with a different address gives no request.
- R4: A channel B data check passes when ((bus_data XOR compare) AND NOT mask) is zero, so a mask bit of 1 leaves that data bit out. With data-enable=1, `bus_data_valid` must be high. With data-enable=0, only the address is compared.
- R5: With a channel's timing bit at 1, a match gives no request in the match cycle. `brk_req` is high in the next cycle in which `insn_done` is high, and the pending request is then cleared.
- R6: A match sets its flag, and the flag stays 1 until a control write puts 0 in that bit.
- R7: If a match and a flag-clearing write fall in the same cycle, the flag ends up set.
- R8: In sequential mode, a channel B hit before any channel A hit gives no request. A channel A hit arms the unit. The next channel B hit requests a break and disarms the unit.
- R9: A control write that changes the sequential bit disarms the unit.
- R10: With enable=0, `brk_req` stays low, but the match flags are still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 to 4) |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data for `reg_sel` |
| bus_valid | input | 1 | Bus cycle present |
| bus_addr | input | W | Bus cycle address |
| bus_data | input | W | Bus cycle data |
| bus_data_valid | input | 1 | `bus_data` is meaningful this cycle |
| insn_done | input | 1 | Instruction completion strobe |
| brk_req | output | 1 | Break request |

## Verification
Two things can happen in the same cycle: a software write that clears match flag A, and a bus cycle that hits channel A. The bench provokes this with one stimulus cycle that carries both the clearing write and the matching address. It then reads the control register on the next cycle and expects flag A still set. A separate write-then-read with no match shows that the clear does work on its own. This separates a design where setting wins from one where the write wins.

// File: rtl/dbg_break_unit.sv
module dbg_break_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [2:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         bus_valid,
  input  logic [W-1:0] bus_addr,
  input  logic [W-1:0] bus_data,
  input  logic         bus_data_valid,
  input  logic         insn_done,
  output logic         brk_req
);
  localparam logic [2:0] S_AA = 3'd0, S_AB = 3'd1, S_CMP = 3'd2, S_MSK = 3'd3, S_CTL = 3'd4;
  localparam int B_FA = 15, B_FB = 14, B_TA = 10, B_DE = 7, B_TB = 6, B_SQ = 3, B_EN = 0;

  logic [W-1:0] addr_a, addr_b, cmp_b, mask_b;
  logic flag_a, flag_b, t_a, den, t_b, seq, en, armed, pend;

  wire ctl_wr   = reg_we && reg_sel == S_CTL;
  wire mode_chg = ctl_wr && (reg_wdata[B_SQ] != seq);
  wire m_a      = bus_valid && bus_addr == addr_a;
  wire d_ok     = !den || (bus_data_valid && (((bus_data ^ cmp_b) & ~mask_b) == '0));
  wire m_b      = bus_valid && bus_addr == addr_b && d_ok;
  wire fire_a   = m_a && !seq;
  wire fire_b   = m_b && (!seq || armed);
  wire now_hit  = (fire_a && !t_a) || (fire_b && !t_b);
  wire late_hit = (fire_a && t_a) || (fire_b && t_b);

  assign brk_req = en && (now_hit || (pend && insn_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_a <= '0;
      addr_b <= '0;
      cmp_b  <= '0;
      mask_b <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        S_AA:    addr_a <= reg_wdata;
        S_AB:    addr_b <= reg_wdata;
        S_CMP:   cmp_b  <= reg_wdata;
        S_MSK:   mask_b <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
      t_a    <= 1'b0;
      den    <= 1'b0;
      t_b    <= 1'b0;
      seq    <= 1'b0;
      en     <= 1'b0;
    end else begin
      flag_a <= m_a || (flag_a && !(ctl_wr && !reg_wdata[B_FA]));
      flag_b <= m_b || (flag_b && !(ctl_wr && !reg_wdata[B_FB]));
      if (ctl_wr) begin
        t_a <= reg_wdata[B_TA];
        den <= reg_wdata[B_DE];
        t_b <= reg_wdata[B_TB];
        seq <= reg_wdata[B_SQ];
        en  <= reg_wdata[B_EN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (mode_chg)         armed <= 1'b0;
      else if (seq && m_a)  armed <= 1'b1;
      else if (fire_b)      armed <= 1'b0;
      pend <= en && ((pend && !insn_done) || late_hit);
    end
  end

  always_comb begin
    case (reg_sel)
      S_AA:    reg_rdata = addr_a;
      S_AB:    reg_rdata = addr_b;
      S_CMP:   reg_rdata = cmp_b;
      S_MSK:   reg_rdata = mask_b;
      S_CTL:   reg_rdata = {{(W-16){1'b0}}, flag_a, flag_b, 3'b000, t_a, 2'b00,
                            den, t_b, 2'b00, seq, 2'b00, en};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbg_break_chk.sv
module dbg_break_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [2:0]   reg_sel,
  input logic [W-1:0] reg_wdata,
  input logic         bus_valid,
  input logic [W-1:0] bus_addr,
  input logic         insn_done,
  input logic         brk_req,
  input logic         en,
  input logic         seq,
  input logic         ta,
  input logic         flag_a,
  input logic         armed,
  input logic [W-1:0] addr_a
);
  p_req_a_before_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !seq && !ta && bus_valid && bus_addr == addr_a) |-> brk_req);

  p_req_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !bus_valid) |-> insn_done);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_a && !(reg_we && reg_sel == 3'd4 && !reg_wdata[15])) |=> flag_a);

  p_flag_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr == addr_a) |=> flag_a);

  p_mode_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 3'd4 && reg_wdata[3] != seq) |=> !armed);

  p_no_req_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !brk_req);
endmodule

bind dbg_break_unit dbg_break_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .bus_valid(bus_valid), .bus_addr(bus_addr), .insn_done(insn_done), .brk_req(brk_req),
  .en(en), .seq(seq), .ta(t_a), .flag_a(flag_a), .armed(armed), .addr_a(addr_a)
);

// File: tb/dbg_break_unit_tb.sv
module dbg_break_unit_tb;
  localparam logic [31:0] AA = 32'h0000_1000, AB = 32'h0000_2000;
  localparam logic [31:0] CMP = 32'hA5A5_0000, MSK = 32'h0000_00FF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, bus_valid = 1'b0, bus_data_valid = 1'b0, insn_done = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0, bus_addr = '0, bus_data = '0;
  logic [31:0] reg_rdata;
  logic brk_req;
  int checks = 0, errors = 0;

  bit q_req[$];
  bit q_ck[$];
  logic [31:0] q_rd[$];
  string q_tag[$];

  always #10 clk = ~clk;

  dbg_break_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_data_valid(bus_data_valid), .insn_done(insn_done), .brk_req(brk_req)
  );

  task automatic step(input bit we, input logic [2:0] sel, input logic [31:0] wd,
                      input bit bv, input logic [31:0] ad, input logic [31:0] dt, input bit dv,
                      input bit dn, input bit er, input bit ck, input logic [31:0] erd,
                      input string tg);
    @(posedge clk); #1;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    bus_valid = bv; bus_addr = ad; bus_data = dt; bus_data_valid = dv; insn_done = dn;
    q_req.push_back(er); q_ck.push_back(ck); q_rd.push_back(erd); q_tag.push_back(tg);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] v, input string tg);
    step(1'b1, sel, v, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, tg);
  endtask
  task automatic rd(input logic [31:0] v, input string tg);
    step(1'b0, 3'd4, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, v, tg);
  endtask
  task automatic bus(input logic [31:0] a, input logic [31:0] d, input bit dv, input bit er,
                     input string tg);
    step(1'b0, 3'd0, '0, 1'b1, a, d, dv, 1'b0, er, 1'b0, '0, tg);
  endtask
  task automatic done(input bit dn, input bit er, input string tg);
    step(1'b0, 3'd0, '0, 1'b0, '0, '0, 1'b0, dn, er, 1'b0, '0, tg);
  endtask

  always @(negedge clk) begin
    if (q_req.size() > 0) begin
      bit er, ck;
      logic [31:0] erd;
      string tg;
      er = q_req.pop_front(); ck = q_ck.pop_front(); erd = q_rd.pop_front(); tg = q_tag.pop_front();
      checks++;
      if (brk_req !== er) begin
        errors++;
        $display("FAIL %s brk_req actual=%b expected=%b", tg, brk_req, er);
      end
      if (ck) begin
        checks++;
        if (reg_rdata !== erd) begin
          errors++;
          $display("FAIL %s rdata actual=%h expected=%h", tg, reg_rdata, erd);
        end
      end
    end
  end

  initial begin
    repeat (1000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(32'h0, "R1 reset");
    wr(3'd4, 32'hFFFF, "R2 write all");
    rd(32'h04C9, "R2 readback");
    wr(3'd0, AA, "setup"); wr(3'd1, AB, "setup"); wr(3'd2, CMP, "setup"); wr(3'd3, MSK, "setup");
    wr(3'd4, 32'h0001, "setup");
    rd(32'h0001, "R2 enable only");
    bus(AA, '0, 1'b0, 1'b1, "R3 match A");
    rd(32'h8001, "R6 flag A set");
    bus(AA + 4, '0, 1'b0, 1'b0, "R3 other addr");
    wr(3'd4, 32'h8001, "R6 write one");
    rd(32'h8001, "R6 flag kept");
    wr(3'd4, 32'h0001, "R6 clear");
    rd(32'h0001, "R6 flag cleared");
    wr(3'd4, 32'h0081, "R4 data enable");
    bus(AB, 32'hA5A5_0037, 1'b1, 1'b1, "R4 masked bits differ");
    bus(AB, 32'hA5A4_0000, 1'b1, 1'b0, "R4 unmasked bit differs");
    bus(AB, CMP, 1'b0, 1'b0, "R4 no data valid");
    wr(3'd4, 32'h0001, "R4 data disabled");
    bus(AB, 32'h1234_5678, 1'b0, 1'b1, "R4 address only");
    wr(3'd4, 32'h0401, "R5 A after");
    bus(AA, '0, 1'b0, 1'b0, "R5 A no early req");
    done(1'b0, 1'b0, "R5 waiting");
    done(1'b1, 1'b1, "R5 req on done");
    done(1'b1, 1'b0, "R5 pending cleared");
    step(1'b1, 3'd4, 32'h0401, 1'b1, AA, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R7 clear and match");
    rd(32'h8401, "R7 set wins");
    done(1'b1, 1'b1, "R5 drain");
    wr(3'd4, 32'h0401, "R7 plain clear");
    rd(32'h0401, "R7 clear works");
    wr(3'd4, 32'h0041, "R5 B after");
    bus(AB, '0, 1'b0, 1'b0, "R5 B no early req");
    done(1'b1, 1'b1, "R5 B req on done");
    wr(3'd4, 32'h0001, "setup");
    wr(3'd4, 32'h0009, "R8 sequential");
    bus(AB, '0, 1'b0, 1'b0, "R8 B before arm");
    bus(AA, '0, 1'b0, 1'b0, "R8 A arms");
    done(1'b0, 1'b0, "R8 idle");
    bus(AB, '0, 1'b0, 1'b1, "R8 B fires");
    bus(AB, '0, 1'b0, 1'b0, "R8 disarmed");
    bus(AA, '0, 1'b0, 1'b0, "R9 arm");
    wr(3'd4, 32'h0001, "R9 mode change");
    wr(3'd4, 32'h0009, "R9 mode back");
    bus(AB, '0, 1'b0, 1'b0, "R9 arm lost");
    wr(3'd4, 32'h0000, "R10 disable");
    bus(AA, '0, 1'b0, 1'b0, "R10 A no req");
    bus(AB, '0, 1'b0, 1'b0, "R10 B no req");
    rd(32'hC000, "R10 flags still set");
    @(posedge clk); @(negedge clk); #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule